// File: doc/BRIEF.md
# Programmable AND-OR Macrocell Array

This block is a small field-configurable logic array. Twelve dedicated inputs and ten feedback signals, one from each macrocell, form the array signals. Every product term is an AND over a chosen set of true and complement literals of those signals. Each of the ten macrocells ORs its own group of product terms. Groups hold between 8 and 16 terms, depending on the macrocell. The macrocell then presents the result at its pin in one of four modes: from a register or straight from the OR gate, with either polarity. One dedicated product term per macrocell drives the output enable of its pin.

Two more product terms act on all ten registers together. One clears them asynchronously. The other sets them at the next clock edge. The whole behaviour comes from a single flat configuration vector that is held steady while the array runs. The pads sit outside the block, so the value seen on each pad comes back in on a separate pin-input bus.

Top module: `pla_array`

## Requirements
- R1: While `rst_n` is low every macrocell register holds 0. The pin then shows 0 for a registered active-high macrocell and 1 for a registered active-low one.
- R2: Array signal k is `in_bus[k]` for k in 0..11 and the feedback of macrocell k-12 for k in 12..21. Term t occupies `cfg[t*44 +: 44]`: bit 2k connects the true literal of signal k and bit 2k+1 connects its complement. A term is the AND of its connected literals, and a term with no connected literal is 0.
- R3: Term 0 is the asynchronous clear term and term 1 is the synchronous set term. For each macrocell m in ascending order there follows one enable term and then its sum terms. The sum-term counts for m = 0..9 are 8, 10, 12, 14, 16, 16, 14, 12, 10, 8. The macrocell's sum is the OR of exactly those terms.
- R4: `cfg[5808+2m]` set selects the register for macrocell m and clear selects the sum directly. `cfg[5809+2m]` set inverts the pin value.
- R5: `pin_oe[m]` equals the value of macrocell m's enable term.
- R6: The feedback of a registered macrocell is its register. The feedback of a combinational macrocell is `pin_in[m]`.
- R7: While the clear term is true all registers are 0 at once, without waiting for a clock edge.
- R8: While the set term is true and the clear term is false, every register becomes 1 at the next rising clock edge.
- R9: When the clear and set terms are both true, the registers stay 0.
- R10: Otherwise each register loads its macrocell's sum at every rising clock edge, whichever mode is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| rst_n | input | 1 | Power-up clear, active low, asynchronous |
| in_bus | input | 12 | Dedicated array inputs |
| cfg | input | 5828 | Configuration vector: term literals, then two mode bits per macrocell |
| pin_in | input | 10 | Value present on each pad, used as combinational feedback |
| pin_out | output | 10 | Data driven toward each pad |
| pin_oe | output | 10 | Output enable of each pad |

## Verification
A register that loads the wrong value shows up on `pin_out` just after the next rising edge when its macrocell is registered. When it is not, the error appears in the same cycle on any pin whose terms use that feedback. A fault in the clear path shows within the cycle in which the clear term rises. A fault in the set path shows one edge after the set term is seen. The reference model recomputes every pin and enable from the literal bits each cycle, so a fault in the term decoding or in the layout of the term groups appears as a mismatch as soon as stimulus touches the affected term.

// File: rtl/pla_pkg.sv
`timescale 1ns/1ps
package pla_pkg;
  localparam int N_IN    = 12;
  localparam int N_MC    = 10;
  localparam int N_SIG   = N_IN + N_MC;
  localparam int LIT_W   = 2 * N_SIG;
  localparam int PT_MIN  = 8;
  localparam int PT_STEP = 2;
  localparam int AR_TERM = 0;
  localparam int SP_TERM = 1;

  // sum-term budget: grows toward the middle macrocells, symmetric about the centre
  function automatic int pt_count(input int m);
    int d;
    d = (m < (N_MC - 1 - m)) ? m : (N_MC - 1 - m);
    return PT_MIN + PT_STEP * d;
  endfunction

  // index of the enable term of macrocell m; its sum terms follow it
  function automatic int term_base(input int m);
    int b;
    b = 2;
    for (int j = 0; j < m; j++) b = b + 1 + pt_count(j);
    return b;
  endfunction

  localparam int N_TERMS  = term_base(N_MC);
  localparam int MODE_LSB = N_TERMS * LIT_W;
  localparam int CFG_W    = MODE_LSB + 2 * N_MC;

  // interleave each signal with its complement: even bit true, odd bit inverted
  function automatic logic [LIT_W-1:0] expand_lits(input logic [N_SIG-1:0] s);
    logic [LIT_W-1:0] r;
    for (int k = 0; k < N_SIG; k++) begin
      r[2*k]   = s[k];
      r[2*k+1] = ~s[k];
    end
    return r;
  endfunction

  // AND over the connected literals; an empty mask yields 0
  function automatic logic term_eval(input logic [LIT_W-1:0] lits,
                                     input logic [LIT_W-1:0] mask);
    return (|mask) & (&(lits | ~mask));
  endfunction

  function automatic logic apply_polarity(input logic v, input logic invert);
    return invert ? ~v : v;
  endfunction
endpackage

// File: rtl/pla_term.sv
`timescale 1ns/1ps
module pla_term
  import pla_pkg::*;
(
  input  logic [LIT_W-1:0] lits,
  input  logic [LIT_W-1:0] mask,
  output logic             hit
);
  assign hit = term_eval(lits, mask);
endmodule

// File: rtl/pla_macrocell.sv
`timescale 1ns/1ps
module pla_macrocell
  import pla_pkg::*;
#(
  parameter int PT = 8
)
(
  input  logic                    clk,
  input  logic                    clr,
  input  logic                    preset,
  input  logic [LIT_W-1:0]        lits,
  input  logic [(PT+1)*LIT_W-1:0] plane,
  input  logic                    reg_mode,
  input  logic                    inv_mode,
  input  logic                    pin_in,
  output logic                    sum,
  output logic                    q,
  output logic                    fb,
  output logic                    pin_out,
  output logic                    pin_oe
);
  logic [PT-1:0] pt_hit;
  logic          sel_val;

  // slot 0 of the plane is the enable term
  pla_term u_oe (
    .lits (lits),
    .mask (plane[0 +: LIT_W]),
    .hit  (pin_oe)
  );

  for (genvar i = 0; i < PT; i++) begin : g_pt
    pla_term u_pt (
      .lits (lits),
      .mask (plane[(i+1)*LIT_W +: LIT_W]),
      .hit  (pt_hit[i])
    );
  end

  assign sum = |pt_hit;

  // clear dominates set; set dominates the sum load
  always_ff @(posedge clk or posedge clr) begin
    if (clr)         q <= 1'b0;
    else if (preset) q <= 1'b1;
    else             q <= sum;
  end

  assign sel_val = reg_mode ? q : sum;
  assign pin_out = apply_polarity(sel_val, inv_mode);
  assign fb      = reg_mode ? q : pin_in;
endmodule

// File: rtl/pla_array.sv
`timescale 1ns/1ps
module pla_array
  import pla_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  in_bus,
  input  logic [CFG_W-1:0] cfg,
  input  logic [N_MC-1:0]  pin_in,
  output logic [N_MC-1:0]  pin_out,
  output logic [N_MC-1:0]  pin_oe
);
  logic [N_MC-1:0]  q_vec;
  logic [N_MC-1:0]  sum_vec;
  logic [N_MC-1:0]  fb_vec;
  logic [N_MC-1:0]  mode_reg;
  logic [N_MC-1:0]  mode_inv;
  logic [LIT_W-1:0] lits;
  logic             ar_hit;
  logic             sp_hit;
  logic             async_clr;

  assign lits = expand_lits({fb_vec, in_bus});

  pla_term u_ar (
    .lits (lits),
    .mask (cfg[AR_TERM*LIT_W +: LIT_W]),
    .hit  (ar_hit)
  );

  pla_term u_sp (
    .lits (lits),
    .mask (cfg[SP_TERM*LIT_W +: LIT_W]),
    .hit  (sp_hit)
  );

  assign async_clr = ar_hit | ~rst_n;

  for (genvar g = 0; g < N_MC; g++) begin : g_mc
    localparam int PT   = pt_count(g);
    localparam int BASE = term_base(g);

    assign mode_reg[g] = cfg[MODE_LSB + 2*g];
    assign mode_inv[g] = cfg[MODE_LSB + 2*g + 1];

    pla_macrocell #(.PT(PT)) u_mc (
      .clk      (clk),
      .clr      (async_clr),
      .preset   (sp_hit),
      .lits     (lits),
      .plane    (cfg[BASE*LIT_W +: (PT+1)*LIT_W]),
      .reg_mode (mode_reg[g]),
      .inv_mode (mode_inv[g]),
      .pin_in   (pin_in[g]),
      .sum      (sum_vec[g]),
      .q        (q_vec[g]),
      .fb       (fb_vec[g]),
      .pin_out  (pin_out[g]),
      .pin_oe   (pin_oe[g])
    );
  end
endmodule

// File: rtl/pla_array_chk.sv
`timescale 1ns/1ps
module pla_array_chk
  import pla_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            ar_hit,
  input logic            sp_hit,
  input logic [N_MC-1:0] q_vec,
  input logic [N_MC-1:0] sum_vec,
  input logic [N_MC-1:0] mode_reg,
  input logic [N_MC-1:0] mode_inv,
  input logic [N_MC-1:0] pin_out
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (q_vec == '0));

  // R7, R9
  async_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ar_hit |-> (q_vec == '0));

  // R8
  sync_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_hit && !ar_hit) |=> (ar_hit || (q_vec == '1)));

  // R10
  sum_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sp_hit && !ar_hit) |=> (ar_hit || (q_vec == $past(sum_vec))));

  // R4
  reg_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((pin_out ^ mode_inv ^ q_vec) & mode_reg) == '0));
endmodule

bind pla_array pla_array_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ar_hit   (ar_hit),
  .sp_hit   (sp_hit),
  .q_vec    (q_vec),
  .sum_vec  (sum_vec),
  .mode_reg (mode_reg),
  .mode_inv (mode_inv),
  .pin_out  (pin_out)
);

// File: tb/pla_array_tb.sv
`timescale 1ns/1ps
module pla_array_tb;
  localparam int NI    = 12;
  localparam int NM    = 10;
  localparam int NS    = NI + NM;
  localparam int LW    = 2 * NS;
  localparam int TERMS = 2 + NM + 120;  // 2 globals, 10 enables, 2*(8+10+12+14+16)
  localparam int MODE0 = TERMS * LW;
  localparam int CW    = MODE0 + 2 * NM;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic [NI-1:0] in_bus = '0;
  logic [CW-1:0] cfg_r = '0;
  logic [NM-1:0] pin_in = '0;
  logic [NM-1:0] pin_out, pin_oe;

  int    n_cmp = 0;
  int    n_bad = 0;
  string req = "R1";
  logic [NM-1:0] mq = '0;
  logic [NM-1:0] nq, exp_out, exp_oe;

  always #5 clk = ~clk;

  pla_array u_dut (
    .clk(clk), .rst_n(rst_n), .in_bus(in_bus), .cfg(cfg_r),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic int pt_of(int m);
    return (m < 5) ? 8 + 2*m : 26 - 2*m;
  endfunction

  function automatic int base_of(int m);
    int b = 2;
    for (int j = 0; j < m; j++) b = b + pt_of(j) + 1;
    return b;
  endfunction

  function automatic bit term_on(int t, logic [NS-1:0] s);
    bit any = 0;
    bit val = 1;
    for (int k = 0; k < NS; k++) begin
      if (cfg_r[t*LW + 2*k])     begin any = 1; if (!s[k]) val = 0; end
      if (cfg_r[t*LW + 2*k + 1]) begin any = 1; if (s[k])  val = 0; end
    end
    return any && val;
  endfunction

  function automatic logic [NS-1:0] sigs();
    logic [NS-1:0] s;
    for (int k = 0; k < NI; k++) s[k] = in_bus[k];
    for (int m = 0; m < NM; m++) s[NI+m] = cfg_r[MODE0+2*m] ? mq[m] : pin_in[m];
    return s;
  endfunction

  task automatic add_lit(int t, int k, bit comp);
    cfg_r[t*LW + 2*k + int'(comp)] = 1'b1;
  endtask

  task automatic set_mode(int m, bit regd, bit inv);
    cfg_r[MODE0 + 2*m]     = regd;
    cfg_r[MODE0 + 2*m + 1] = inv;
  endtask

  task automatic model();
    logic [NS-1:0] s;
    logic [NM-1:0] sm;
    bit ar, sp;
    int t;
    s  = sigs();
    ar = term_on(0, s);
    if (ar || !rst_n) begin
      mq = '0;
      s  = sigs();
    end
    sp = term_on(1, s);
    t  = 2;
    for (int m = 0; m < NM; m++) begin
      exp_oe[m] = term_on(t, s);
      t++;
      sm[m] = 1'b0;
      for (int i = 0; i < pt_of(m); i++) begin
        if (term_on(t, s)) sm[m] = 1'b1;
        t++;
      end
      exp_out[m] = (cfg_r[MODE0+2*m] ? mq[m] : sm[m]) ^ cfg_r[MODE0+2*m+1];
    end
    nq = (ar || !rst_n) ? '0 : (sp ? '1 : sm);
  endtask

  task automatic check(string what, logic [NM-1:0] act, logic [NM-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // inputs are set at a falling edge; compare just after, then advance the model at the rising edge
  task automatic step();
    #1;
    model();
    check("pin_out", pin_out, exp_out);
    check("pin_oe", pin_oe, exp_oe);
    @(posedge clk);
    mq = nq;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int b;
    #2 rst_n = 1'b0;
    @(negedge clk);

    // R1: reset clears registers, pins follow polarity
    req = "R1";
    step(); step();
    for (int m = 0; m < NM; m++) set_mode(m, 1'b1, m[0]);
    step(); step();
    n_cmp++;
    if (pin_out !== 10'h2AA) begin
      n_bad++;
      $display("FAIL R1 reset pins: got %h expected %h", pin_out, 10'h2AA);
    end
    rst_n = 1'b1;
    step();

    // R2 R3 R5: AND of literals, OR over the group, enable term
    req = "R2";
    cfg_r = '0;
    b = base_of(0);
    set_mode(0, 1'b0, 1'b0);
    add_lit(b, 11, 1'b0);
    add_lit(b+1, 0, 1'b0); add_lit(b+1, 1, 1'b1);
    add_lit(b+8, 2, 1'b0); add_lit(b+8, 3, 1'b0);
    for (int v = 0; v < 32; v++) begin
      in_bus = '0;
      in_bus[3:0] = v[3:0];
      in_bus[11] = v[4];
      step();
    end

    // R3: largest group and last group reach their final terms
    req = "R3";
    b = base_of(4);
    set_mode(4, 1'b0, 1'b0);
    add_lit(b, 11, 1'b0);
    add_lit(b+16, 5, 1'b0);
    b = base_of(9);
    set_mode(9, 1'b0, 1'b1);
    add_lit(b, 11, 1'b0);
    add_lit(b+8, 6, 1'b1);
    for (int v = 0; v < 8; v++) begin
      in_bus = '0;
      in_bus[5] = v[0]; in_bus[6] = v[1]; in_bus[11] = v[2];
      step();
    end

    // R4 R10: four modes fed by the same term
    req = "R4";
    cfg_r = '0;
    for (int j = 0; j < 4; j++) begin
      int m = j + 1;
      b = base_of(m);
      set_mode(m, j[0], j[1]);
      add_lit(b, 11, 1'b0);
      add_lit(b+1, 4, 1'b0);
    end
    for (int v = 0; v < 12; v++) begin
      in_bus = '0;
      in_bus[11] = 1'b1;
      in_bus[4] = v[0] ^ v[2];
      step();
    end

    // R6: register feedback toggles; combinational feedback follows the pin
    req = "R6";
    cfg_r = '0;
    b = base_of(2); set_mode(2, 1'b1, 1'b0); add_lit(b, 11, 1'b0); add_lit(b+1, NI+2, 1'b1);
    b = base_of(3); set_mode(3, 1'b0, 1'b0); add_lit(b, 11, 1'b0); add_lit(b+1, NI+3, 1'b0);
    b = base_of(5); set_mode(5, 1'b1, 1'b0); add_lit(b, NI+3, 1'b1); add_lit(b+2, NI+3, 1'b0);
    in_bus = '0; in_bus[11] = 1'b1;
    for (int v = 0; v < 10; v++) begin
      pin_in = '0;
      pin_in[3] = v[1];
      step();
    end

    // R7 R8 R9: shared clear and set terms
    req = "R8";
    add_lit(0, 9, 1'b0);
    add_lit(1, 10, 1'b0);
    for (int m = 0; m < NM; m++) set_mode(m, 1'b1, m[1]);
    in_bus = '0; in_bus[11] = 1'b1; in_bus[10] = 1'b1;
    step(); step();
    in_bus[10] = 1'b0;
    step();
    req = "R7";
    in_bus[9] = 1'b1;
    step(); step();
    in_bus[9] = 1'b0;
    step();
    in_bus[10] = 1'b1;
    step();
    req = "R9";
    in_bus[9] = 1'b1;
    step(); step();
    in_bus[9] = 1'b0;
    step(); step();

    // R10: sparse random configurations
    req = "R10";
    for (int c = 0; c < 20; c++) begin
      cfg_r = '0;
      for (int t = 2; t < TERMS; t++) begin
        int nl = $urandom_range(0, 2);
        for (int l = 0; l < nl; l++) add_lit(t, $urandom_range(0, NS-1), 1'($urandom_range(0, 1)));
      end
      for (int l = 0; l < 3; l++) add_lit(0, $urandom_range(0, NI-1), 1'($urandom_range(0, 1)));
      for (int l = 0; l < 2; l++) add_lit(1, $urandom_range(0, NS-1), 1'($urandom_range(0, 1)));
      for (int m = 0; m < NM; m++) set_mode(m, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      for (int k = 0; k < 100; k++) begin
        in_bus = NI'($urandom);
        pin_in = NM'($urandom);
        step();
      end
    end

    summary();
    $finish;
  end
endmodule